// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block sits beside a 16-entry UART receive FIFO and turns the FIFO's occupancy, the push and read strobes and the line-error flag into the receive-side status and interrupt outputs. It raises a level interrupt when the FIFO holds at least the programmed number of characters, and a character-timeout interrupt when characters are stranded below that level. It also forwards a line-status interrupt and encodes all pending sources into one prioritised identification code for the CPU to read.

The timeout is measured in 16x baud ticks. Its length is four character times, and the character length is derived from the programmed word length, the parity enable and the stop-bit setting, so the delay scales with the baud rate. With the FIFO enabled and the receive interrupt enable cleared, the block runs in polled mode: no receive interrupt is signalled, and software relies on the data-ready bit. `fifoCount` is the registered occupancy before this cycle's push or read. The FIFO applies the push or read at the next clock edge.

Top module: `rx_fifo_irq`

## Requirements
- R1: `dataReady` is 1 exactly when `fifoCount` is non-zero, in both interrupt and polled mode.
- R2: `rdaIrq` is 1 exactly when `fifoEn` and `rxIntEn` are 1, `fifoCount` is non-zero and `fifoCount >= trigLevel`. It falls in the same cycle the count drops below the level.
- R3: One character time is 16 x (1 start + data bits + parity bit + stop bits) ticks of `baudTick`. `wordLen` 0..3 selects 5..8 data bits, `parityEn`=1 adds one bit, and `twoStop`=1 gives two stop bits instead of one.
- R4: The timeout becomes pending at the clock edge of the tick that completes 4 character times. These ticks must be counted while the FIFO is enabled and non-empty, with no push and no read since the timer last restarted. It is not pending one tick earlier.
- R5: While no timeout is pending, a push restarts the timer from zero. A push while a timeout is pending leaves it pending.
- R6: A CPU read (`readStb`) clears a pending timeout at the next edge and restarts the timer from zero.
- R7: A cycle with `fifoEn`=0 or `fifoCount`=0 clears the timer and any pending timeout.
- R8: `timeoutIrq` is the pending timeout gated by `fifoEn` and `rxIntEn`. With `rxIntEn`=0 (polled mode) neither `rdaIrq` nor `timeoutIrq` is ever 1.
- R9: `lineIrq` is 1 exactly when `lineIntEn` and `lineErr` are both 1.
- R10: `irqId` is 4'h6 when `lineIrq` is set. Otherwise it is 4'h4 when `rdaIrq` is set, then 4'hC when `timeoutIrq` is set, and 4'h1 when nothing is pending.
- R11: During and right after reset no timeout is pending and the timer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoCount | input | 5 | Current receive FIFO occupancy (0..16) |
| pushStb | input | 1 | A character enters the FIFO this cycle |
| readStb | input | 1 | The CPU reads one character this cycle |
| trigLevel | input | 5 | Programmed trigger level (1..16) |
| fifoEn | input | 1 | FIFO mode enable |
| rxIntEn | input | 1 | Receive data interrupt enable |
| lineIntEn | input | 1 | Line status interrupt enable |
| lineErr | input | 1 | A line error is flagged in the status register |
| baudTick | input | 1 | 16x baud clock enable |
| wordLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit present |
| twoStop | input | 1 | Two stop bits |
| dataReady | output | 1 | Data-ready status bit |
| rdaIrq | output | 1 | Received-data-available interrupt |
| timeoutIrq | output | 1 | Character-timeout interrupt |
| lineIrq | output | 1 | Line-status interrupt |
| irqId | output | 4 | Prioritised interrupt identification code |

## Verification
The bench walks the timeout counter up to its threshold and checks both the cycle before and the cycle of firing. A design that is off by one tick fails there, and so does one that miscounts the parity or second stop bit, since that shifts the threshold by 64 ticks. It pushes while a timeout is pending: a design that restarts the timer on every push would drop the interrupt. It also pushes shortly before the threshold: a design that ignores pushes fires early. It toggles the FIFO enable and empties the FIFO to catch a stale pending flag. Random traffic then mixes line errors with trigger and timeout events, which exposes a wrong priority order in the identification code.

// File: rtl/rx_fifo_irq_pkg.sv
package rx_fifo_irq_pkg;

  // Commands from the control module to the timeout timer
  typedef struct packed {
    logic clear;    // drop count and pending flag
    logic restart;  // restart count unless a timeout is pending
    logic tick;     // one 16x baud tick elapsed
  } tmrCmd_t;

  typedef enum logic [3:0] {
    ID_NONE = 4'h1,
    ID_RDA  = 4'h4,
    ID_LINE = 4'h6,
    ID_TMO  = 4'hC
  } irqId_e;

endpackage

// File: rtl/rx_fifo_irq_timer.sv
module rx_fifo_irq_timer
  import rx_fifo_irq_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TO_CHARS   = 4,
  parameter int TMR_W      = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrCmd_t       cmd,
  input  logic [1:0]    wordLen,
  input  logic          parityEn,
  input  logic          twoStop,
  output logic          toPend
);

  localparam int BASE_BITS = 6;  // start bit plus the five-bit minimum word

  logic [TMR_W-1:0] bitCnt;
  logic [TMR_W-1:0] thr;
  logic [TMR_W-1:0] toCnt;
  logic [TMR_W-1:0] nxtCnt;

  always_comb begin
    bitCnt = TMR_W'(BASE_BITS) + TMR_W'(wordLen) + TMR_W'(parityEn)
           + (twoStop ? TMR_W'(2) : TMR_W'(1));
    thr    = bitCnt * TMR_W'(OVERSAMPLE * TO_CHARS);
    nxtCnt = toCnt + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt  <= '0;
      toPend <= 1'b0;
    end else if (cmd.clear) begin
      toCnt  <= '0;
      toPend <= 1'b0;
    end else if (!toPend) begin
      if (cmd.restart) begin
        toCnt <= '0;
      end else if (cmd.tick) begin
        toCnt <= nxtCnt;
        if (nxtCnt >= thr) toPend <= 1'b1;
      end
    end
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toPend && !cmd.clear) |=> toPend);

  // R4
  pend_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toPend) |-> $past(cmd.tick && !cmd.restart));

  // R11
  reset_clean_chk: assert property (@(posedge clk)
    !rstN |=> (!toPend && toCnt == '0));

endmodule

// File: rtl/rx_fifo_irq_ctrl.sv
module rx_fifo_irq_ctrl
  import rx_fifo_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             pushStb,
  input  logic             readStb,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             fifoEn,
  input  logic             rxIntEn,
  input  logic             lineIntEn,
  input  logic             lineErr,
  input  logic             baudTick,
  input  logic             toPend,
  output tmrCmd_t          cmd,
  output logic             dataReady,
  output logic             rdaIrq,
  output logic             timeoutIrq,
  output logic             lineIrq,
  output logic [3:0]       irqId
);

  logic notEmpty;
  logic active;

  always_comb begin
    notEmpty    = (fifoCount != '0);
    active      = fifoEn && notEmpty;
    cmd.clear   = !active || readStb;
    cmd.restart = pushStb;
    cmd.tick    = baudTick;

    dataReady  = notEmpty;
    rdaIrq     = fifoEn && rxIntEn && notEmpty && (fifoCount >= trigLevel);
    timeoutIrq = fifoEn && rxIntEn && toPend;
    lineIrq    = lineIntEn && lineErr;

    if (lineIrq)         irqId = ID_LINE;
    else if (rdaIrq)     irqId = ID_RDA;
    else if (timeoutIrq) irqId = ID_TMO;
    else                 irqId = ID_NONE;
  end

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    readStb |=> !toPend);

  // R7
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn || fifoCount == '0) |=> !toPend);

  // R8
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEn |-> (!rdaIrq && !timeoutIrq));

  // R10
  id_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqId == 4'h1) || (irqId == 4'h4) || (irqId == 4'h6) || (irqId == 4'hC));

  // R1
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |-> !dataReady);

endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rx_fifo_irq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OVERSAMPLE = 16,
  parameter int TO_CHARS   = 4,
  parameter int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             pushStb,
  input  logic             readStb,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             fifoEn,
  input  logic             rxIntEn,
  input  logic             lineIntEn,
  input  logic             lineErr,
  input  logic             baudTick,
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic             twoStop,
  output logic             dataReady,
  output logic             rdaIrq,
  output logic             timeoutIrq,
  output logic             lineIrq,
  output logic [3:0]       irqId
);

  localparam int MAX_BITS = 12;
  localparam int TMR_W    = $clog2(MAX_BITS * OVERSAMPLE * TO_CHARS + 1);

  tmrCmd_t cmd;
  logic    toPend;

  rx_fifo_irq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fifoCount  (fifoCount),
    .pushStb    (pushStb),
    .readStb    (readStb),
    .trigLevel  (trigLevel),
    .fifoEn     (fifoEn),
    .rxIntEn    (rxIntEn),
    .lineIntEn  (lineIntEn),
    .lineErr    (lineErr),
    .baudTick   (baudTick),
    .toPend     (toPend),
    .cmd        (cmd),
    .dataReady  (dataReady),
    .rdaIrq     (rdaIrq),
    .timeoutIrq (timeoutIrq),
    .lineIrq    (lineIrq),
    .irqId      (irqId)
  );

  rx_fifo_irq_timer #(
    .OVERSAMPLE (OVERSAMPLE),
    .TO_CHARS   (TO_CHARS),
    .TMR_W      (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .wordLen  (wordLen),
    .parityEn (parityEn),
    .twoStop  (twoStop),
    .toPend   (toPend)
  );

endmodule

// File: tb/rx_fifo_irq_tb.sv
module rx_fifo_irq_tb;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] fifoCount;
  logic       pushStb, readStb, fifoEn, rxIntEn, lineIntEn, lineErr, baudTick;
  logic [4:0] trigLevel;
  logic [1:0] wordLen;
  logic       parityEn, twoStop;
  logic       dataReady, rdaIrq, timeoutIrq, lineIrq;
  logic [3:0] irqId;

  // configuration shadows, applied at the next driving point
  bit [4:0] nTrig;
  bit       nFifoEn, nRxIntEn, nLineIntEn, nLineErr, nParity, nTwoStop;
  bit [1:0] nWl;

  int  cnt;      // bench-side FIFO occupancy
  int  mCnt;     // reference timer
  bit  mPend;
  int  vectors = 0;
  int  misses  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  rx_fifo_irq u_dut (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .pushStb(pushStb),
    .readStb(readStb), .trigLevel(trigLevel), .fifoEn(fifoEn),
    .rxIntEn(rxIntEn), .lineIntEn(lineIntEn), .lineErr(lineErr),
    .baudTick(baudTick), .wordLen(wordLen), .parityEn(parityEn),
    .twoStop(twoStop), .dataReady(dataReady), .rdaIrq(rdaIrq),
    .timeoutIrq(timeoutIrq), .lineIrq(lineIrq), .irqId(irqId)
  );

  // R3: four character times in 16x ticks
  function automatic int thrOf(bit [1:0] wl, bit par, bit ts);
    return (6 + int'(wl) + int'(par) + (ts ? 2 : 1)) * 16 * 4;
  endfunction

  function automatic bit [3:0] expId(bit ln, bit rd, bit to);
    if (ln) return 4'h6;
    if (rd) return 4'h4;
    if (to) return 4'hC;
    return 4'h1;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit p, bit r, bit t);
    bit eDr, eRda, eTo, eLn;
    bit act;
    @(negedge clk);
    if (cnt >= DEPTH) p = 1'b0;
    if (cnt == 0)     r = 1'b0;
    fifoCount = 5'(cnt);  pushStb = p;  readStb = r;  baudTick = t;
    trigLevel = nTrig;    fifoEn = nFifoEn;  rxIntEn = nRxIntEn;
    lineIntEn = nLineIntEn;  lineErr = nLineErr;
    wordLen = nWl;  parityEn = nParity;  twoStop = nTwoStop;
    #1;
    eDr  = (cnt != 0);
    eRda = nFifoEn && nRxIntEn && (cnt != 0) && (cnt >= int'(nTrig));
    eTo  = mPend && nFifoEn && nRxIntEn;
    eLn  = nLineIntEn && nLineErr;
    vectors++;
    if (dataReady !== eDr)  begin misses++; $display("FAIL R1 dataReady actual=%b expected=%b", dataReady, eDr); end
    if (rdaIrq !== eRda)    begin misses++; $display("FAIL R2 rdaIrq actual=%b expected=%b", rdaIrq, eRda); end
    if (timeoutIrq !== eTo) begin misses++; $display("FAIL R8 timeoutIrq actual=%b expected=%b", timeoutIrq, eTo); end
    if (lineIrq !== eLn)    begin misses++; $display("FAIL R9 lineIrq actual=%b expected=%b", lineIrq, eLn); end
    if (irqId !== expId(eLn, eRda, eTo))
      begin misses++; $display("FAIL R10 irqId actual=%h expected=%h", irqId, expId(eLn, eRda, eTo)); end
    // reference timer update for the coming edge
    act = nFifoEn && (cnt != 0);
    if (!act || r) begin
      mCnt = 0; mPend = 1'b0;
    end else if (!mPend) begin
      if (p) mCnt = 0;
      else if (t) begin
        mCnt++;
        if (mCnt >= thrOf(nWl, nParity, nTwoStop)) mPend = 1'b1;
      end
    end
    cnt = cnt + int'(p) - int'(r);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cnt = 0; mCnt = 0; mPend = 1'b0;
    nTrig = 5'd8; nFifoEn = 1; nRxIntEn = 1; nLineIntEn = 0; nLineErr = 0;
    nWl = 2'd0; nParity = 0; nTwoStop = 0;
    rstN = 1'b0;
    fifoCount = '0; pushStb = 0; readStb = 0; baudTick = 0;
    trigLevel = nTrig; fifoEn = 1; rxIntEn = 1; lineIntEn = 0; lineErr = 0;
    wordLen = 0; parityEn = 0; twoStop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 timeoutIrq", {3'b0, timeoutIrq}, 4'h0);
    chk("R11 irqId", irqId, 4'h1);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    chk("R11 timeoutIrq after reset", {3'b0, timeoutIrq}, 4'h0);

    // R4: boundary at 448 ticks (5 data bits, no parity, one stop)
    step(1'b1, 1'b0, 1'b0);
    ticks(447);
    step(1'b0, 1'b0, 1'b0);
    chk("R4 one tick short", {3'b0, timeoutIrq}, 4'h0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R4 at threshold", {3'b0, timeoutIrq}, 4'h1);
    chk("R10 timeout id", irqId, 4'hC);

    // R5: push while pending keeps it
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk("R5 pending survives push", {3'b0, timeoutIrq}, 4'h1);

    // R6: a read clears it
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R6 read clears", {3'b0, timeoutIrq}, 4'h0);
    chk("R1 still ready", {3'b0, dataReady}, 4'h1);

    // R5: push restarts the timer while not pending
    ticks(300);
    step(1'b1, 1'b0, 1'b0);
    ticks(447);
    step(1'b0, 1'b0, 1'b0);
    chk("R5 restart delays", {3'b0, timeoutIrq}, 4'h0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R5 fires after restart", {3'b0, timeoutIrq}, 4'h1);

    // R7: FIFO disable clears the pending flag
    nFifoEn = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    nFifoEn = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk("R7 disable clears", {3'b0, timeoutIrq}, 4'h0);

    // R3: 8 data bits, parity, two stop bits -> 768 ticks
    nWl = 2'd3; nParity = 1'b1; nTwoStop = 1'b1;
    step(1'b0, 1'b1, 1'b0);
    ticks(767);
    step(1'b0, 1'b0, 1'b0);
    chk("R3 long frame short", {3'b0, timeoutIrq}, 4'h0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R3 long frame fires", {3'b0, timeoutIrq}, 4'h1);

    // R9/R10: line status outranks everything
    nLineIntEn = 1'b1; nLineErr = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk("R10 line first", irqId, 4'h6);
    nLineErr = 1'b0;

    // R8: polled mode masks receive interrupts, R1 still tracks occupancy
    nRxIntEn = 1'b0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1);
    chk("R8 polled rda masked", {3'b0, rdaIrq}, 4'h0);
    chk("R1 polled ready", {3'b0, dataReady}, 4'h1);
    nRxIntEn = 1'b1;

    // R2: trigger level boundary
    nTrig = 5'd14;
    while (cnt > 13) step(1'b0, 1'b1, 1'b0);
    while (cnt < 13) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R2 below level", {3'b0, rdaIrq}, 4'h0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R2 at level", {3'b0, rdaIrq}, 4'h1);
    chk("R10 rda id", irqId, 4'h4);

    // R1: drain to empty
    while (cnt > 0) step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R1 empty clears ready", {3'b0, dataReady}, 4'h0);

    // random traffic mixing all sources
    for (int seg = 0; seg < 30; seg++) begin
      int pushP, readP;
      bit [1:0] tsel;
      tsel       = 2'($urandom_range(0, 3));
      nTrig      = (tsel == 0) ? 5'd1 : (tsel == 1) ? 5'd4 : (tsel == 2) ? 5'd8 : 5'd14;
      nFifoEn    = ($urandom_range(0, 7) != 0);
      nRxIntEn   = ($urandom_range(0, 3) != 0);
      nLineIntEn = 1'($urandom_range(0, 1));
      nWl        = 2'($urandom_range(0, 3));
      nParity    = 1'($urandom_range(0, 1));
      nTwoStop   = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 0) begin pushP = 500; readP = 2000; end
      else begin pushP = 4; readP = 5; end
      for (int i = 0; i < 1500; i++) begin
        nLineErr = ($urandom_range(0, 7) == 0);
        step($urandom_range(0, pushP - 1) == 0,
             $urandom_range(0, readP - 1) == 0,
             $urandom_range(0, 3) != 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule